// File: doc/BRIEF.md
# Cascadable Unsigned Magnitude Comparator

This block compares two unsigned words and reports whether the first is greater than, equal to, or less than the second on three separate result lines. It is built from identical slices of `SLICE_W` bits each. A slice decides the result from its own bits whenever those bits differ. When they match, it passes on the verdict carried in on three cascade lines from the next less significant slice. The default build chains two 4-bit slices into an 8-bit comparator.

The slices are wired from least significant to most significant. Slice 0 receives the block's cascade inputs, and every later slice receives the outputs of the slice below it. The last slice drives the block outputs. For a plain compare of one word, the user drives the equal cascade line high and the other two low. Wider comparisons are built by feeding this block's outputs into the cascade inputs of a further instance. The block is purely combinational and has no clock.

Top module: `mag_cmp_chain`

## Requirements
- R1: When the words differ and A is numerically greater as an unsigned number (bit 0 least significant), `a_gt_b` is 1 and the other two outputs are 0.
- R2: `a_eq_b` can be 1 without cascade help only when every bit of A matches the bit of B in the same position. With the equal cascade line high and the other two low, equal words give `a_eq_b`=1, `a_gt_b`=0 and `a_lt_b`=0.
- R3: When the words differ and A is numerically smaller, `a_lt_b` is 1 and the other two outputs are 0.
- R4: Inside a slice whose bits differ, the cascade lines have no effect. The most significant differing bit alone chooses greater or less.
- R5: Inside a slice whose bits are all equal, the three outputs equal the three cascade inputs, line for line (greater to greater, equal to equal, less to less).
- R6: When exactly one cascade input is 1, exactly one output is 1.
- R7: Slice k compares bits [k*SLICE_W +: SLICE_W], with higher k more significant. With only the equal cascade input high, the chain gives the unsigned compare of the full `SLICE_W*NUM_SLICES`-bit words.
- R8: When the upper slice's bits are equal, the result of the lower slice decides the outputs of the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_word | input | SLICE_W*NUM_SLICES | Operand A, unsigned |
| b_word | input | SLICE_W*NUM_SLICES | Operand B, unsigned |
| cas_gt | input | 1 | Greater verdict from a less significant block |
| cas_eq | input | 1 | Equal verdict from a less significant block (tie high when unused) |
| cas_lt | input | 1 | Less verdict from a less significant block |
| a_gt_b | output | 1 | A greater than B |
| a_eq_b | output | 1 | A equal to B |
| a_lt_b | output | 1 | A less than B |

## Verification
The assertions in each slice check on every input change that differing slices ignore their cascade, that equal slices copy it, and that a one-hot cascade gives one-hot outputs. At the top, an assertion checks that a tied-equal cascade yields the plain wide compare. What only the bench scenarios can show is that the bit significance is correct across slices: the lower slice must decide only when the upper bits tie. The bench exercises this with directed cases of equal upper slices. It also shows that every pair of 4-bit values, under each cascade verdict, maps to the expected result.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;
   typedef struct packed {
      logic gt;
      logic eq;
      logic lt;
   } cmp_res_t;

   localparam cmp_res_t RES_EQ_TIE = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};
endpackage

// File: rtl/cmp_bit_eq.sv
module cmp_bit_eq #(
   parameter int W = 4
) (
   input  logic [W-1:0] a_v,
   input  logic [W-1:0] b_v,
   output logic [W-1:0] same_v
);
   if (W < 1) begin : g_bad_w
      $error("cmp_bit_eq: W must be at least 1");
   end

   for (genvar i = 0; i < W; i++) begin : g_xnor
      assign same_v[i] = ~(a_v[i] ^ b_v[i]);
   end
endmodule

// File: rtl/cmp_slice.sv
module cmp_slice
   import mag_cmp_pkg::*;
#(
   parameter int W             = 4,
   parameter bit SCAN_PRIORITY = 1'b1
) (
   input  logic [W-1:0] a_sl,
   input  logic [W-1:0] b_sl,
   input  cmp_res_t     cin,
   output cmp_res_t     cout
);
   if (W < 1) begin : g_bad_w
      $error("cmp_slice: W must be at least 1");
   end

   logic [W-1:0] same_v;
   logic         loc_eq;
   logic         loc_gt;
   logic         loc_lt;

   cmp_bit_eq #(.W(W)) u_eq (
      .a_v   (a_sl),
      .b_v   (b_sl),
      .same_v(same_v)
   );

   assign loc_eq = &same_v;

   if (SCAN_PRIORITY) begin : g_scan
      // above_eq[i]: every bit more significant than i matches
      logic [W-1:0] above_eq;
      logic [W-1:0] win_a;
      logic [W-1:0] win_b;
      assign above_eq[W-1] = 1'b1;
      for (genvar i = W - 2; i >= 0; i--) begin : g_prefix
         assign above_eq[i] = above_eq[i+1] & same_v[i+1];
      end
      for (genvar i = 0; i < W; i++) begin : g_win
         assign win_a[i] = above_eq[i] & a_sl[i] & ~b_sl[i];
         assign win_b[i] = above_eq[i] & ~a_sl[i] & b_sl[i];
      end
      assign loc_gt = |win_a;
      assign loc_lt = |win_b;
   end else begin : g_arith
      assign loc_gt = (a_sl > b_sl);
      assign loc_lt = ~loc_gt & ~loc_eq;
   end

   assign cout.gt = loc_gt | (loc_eq & cin.gt);
   assign cout.eq = loc_eq & cin.eq;
   assign cout.lt = loc_lt | (loc_eq & cin.lt);

   always_comb begin
      AST_DIFF_GT: assert ((a_sl == b_sl) || (cout.gt == (a_sl > b_sl)))
         else $error("slice greater mismatch"); // R1 R4
      AST_DIFF_LT: assert ((a_sl == b_sl) || (cout.lt == (a_sl < b_sl)))
         else $error("slice less mismatch"); // R3 R4
      AST_DIFF_NO_EQ: assert ((a_sl == b_sl) || !cout.eq)
         else $error("slice equal on differing bits"); // R2
      AST_TIE_COPY: assert ((a_sl != b_sl) || (cout == cin))
         else $error("slice did not copy cascade"); // R5
      AST_ONE_HOT: assert (!$onehot(cin) || $onehot(cout))
         else $error("slice outputs not one-hot"); // R6
   end
endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
   import mag_cmp_pkg::*;
#(
   parameter int SLICE_W       = 4,
   parameter int NUM_SLICES    = 2,
   parameter bit SCAN_PRIORITY = 1'b1
) (
   input  logic [SLICE_W*NUM_SLICES-1:0] a_word,
   input  logic [SLICE_W*NUM_SLICES-1:0] b_word,
   input  logic                          cas_gt,
   input  logic                          cas_eq,
   input  logic                          cas_lt,
   output logic                          a_gt_b,
   output logic                          a_eq_b,
   output logic                          a_lt_b
);
   localparam int WORD_W = SLICE_W * NUM_SLICES;

   if (SLICE_W < 1) begin : g_bad_slice
      $error("mag_cmp_chain: SLICE_W must be at least 1");
   end
   if (NUM_SLICES < 1) begin : g_bad_count
      $error("mag_cmp_chain: NUM_SLICES must be at least 1");
   end

   cmp_res_t link [NUM_SLICES+1];

   assign link[0] = '{gt: cas_gt, eq: cas_eq, lt: cas_lt};

   for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
      cmp_slice #(
         .W            (SLICE_W),
         .SCAN_PRIORITY(SCAN_PRIORITY)
      ) u_slice (
         .a_sl(a_word[k*SLICE_W +: SLICE_W]),
         .b_sl(b_word[k*SLICE_W +: SLICE_W]),
         .cin (link[k]),
         .cout(link[k+1])
      );
   end

   assign a_gt_b = link[NUM_SLICES].gt;
   assign a_eq_b = link[NUM_SLICES].eq;
   assign a_lt_b = link[NUM_SLICES].lt;

   always_comb begin
      AST_WIDE_COMPARE: assert (!(cas_eq && !cas_gt && !cas_lt) ||
                                ({a_gt_b, a_eq_b, a_lt_b} ==
                                 {(a_word > b_word), (a_word == b_word), (a_word < b_word)}))
         else $error("chain compare mismatch, width %0d", WORD_W); // R7
   end
endmodule

// File: tb/tb_mag_cmp_chain.sv
module tb_mag_cmp_chain;
   localparam int SW = 4;
   localparam int NS = 2;
   localparam int WW = SW * NS;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   int n_vec  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // 8-bit chain under test
   logic [WW-1:0] a8, b8;
   logic [2:0]    c8;
   logic gt8, eq8, lt8;

   mag_cmp_chain #(.SLICE_W(SW), .NUM_SLICES(NS)) dut (
      .a_word(a8), .b_word(b8),
      .cas_gt(c8[2]), .cas_eq(c8[1]), .cas_lt(c8[0]),
      .a_gt_b(gt8), .a_eq_b(eq8), .a_lt_b(lt8)
   );

   // single 4-bit slice for exhaustive coverage
   logic [SW-1:0] a4, b4;
   logic [2:0]    c4;
   logic gt4, eq4, lt4;

   mag_cmp_chain #(.SLICE_W(SW), .NUM_SLICES(1)) dut1 (
      .a_word(a4), .b_word(b4),
      .cas_gt(c4[2]), .cas_eq(c4[1]), .cas_lt(c4[0]),
      .a_gt_b(gt4), .a_eq_b(eq4), .a_lt_b(lt4)
   );

   // cascade encoding {gt,eq,lt}
   function automatic logic [2:0] ref_cmp(input logic [WW-1:0] x, input logic [WW-1:0] y,
                                          input logic [2:0] cin);
      if (x > y)      return 3'b100;
      else if (x < y) return 3'b001;
      else            return cin;
   endfunction

   task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got gt/eq/lt=%b expected %b", req, got, exp);
      end
   endtask

   task automatic run4(input logic [SW-1:0] x, input logic [SW-1:0] y, input logic [2:0] cin);
      string req;
      a4 = x; b4 = y; c4 = cin;
      @(negedge clk);
      if (x > y)              req = (cin == 3'b010) ? "R1" : "R4";
      else if (x < y)         req = (cin == 3'b010) ? "R3" : "R4";
      else                    req = (cin == 3'b010) ? "R2" : "R5";
      check(req, {gt4, eq4, lt4}, ref_cmp({4'd0, x}, {4'd0, y}, cin));
      // R6: one-hot cascade gives one-hot result
      if ($countones(cin) == 1) check("R6", 3'(($countones({gt4, eq4, lt4}) == 1)), 3'd1);
   endtask

   task automatic run8(input logic [WW-1:0] x, input logic [WW-1:0] y, input logic [2:0] cin);
      a8 = x; b8 = y; c8 = cin;
      @(negedge clk);
      check((x[WW-1:SW] == y[WW-1:SW]) ? "R8" : "R7", {gt8, eq8, lt8}, ref_cmp(x, y, cin));
   endtask

   initial begin
      int seed;
      seed = 32'h1D2C_3B4A;
      void'($urandom(seed));
      a4 = '0; b4 = '0; c4 = 3'b010;
      a8 = '0; b8 = '0; c8 = 3'b010;
      repeat (2) @(negedge clk);
      // reset-like idle state: zeros with equal tie report equal (R2)
      check("R2", {gt8, eq8, lt8}, 3'b010);

      // exhaustive 4-bit slice under every one-hot cascade (R1..R6)
      for (int ci = 0; ci < 3; ci++) begin
         for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
               run4(4'(x), 4'(y), 3'(1 << ci));
            end
         end
      end

      // directed corners on the 8-bit chain (R7, R8)
      run8(8'h00, 8'h00, 3'b010);
      run8(8'hFF, 8'hFF, 3'b010);
      run8(8'hFF, 8'h00, 3'b010);
      run8(8'h00, 8'hFF, 3'b010);
      run8(8'h80, 8'h7F, 3'b010);
      run8(8'h0F, 8'h10, 3'b010);
      run8(8'h5A, 8'h59, 3'b010);
      run8(8'hA3, 8'hA7, 3'b010);
      run8(8'h3C, 8'h3C, 3'b100);
      run8(8'h3C, 8'h3C, 3'b001);
      run8(8'h41, 8'h40, 3'b001);  // R4 across the chain
      run8(8'h40, 8'h41, 3'b100);  // R4 across the chain

      // constrained random: half with matching upper slice
      for (int i = 0; i < 3000; i++) begin
         logic [WW-1:0] x, y;
         x = 8'($urandom);
         y = 8'($urandom);
         if (i % 2 == 0) y[WW-1:SW] = x[WW-1:SW];
         if (i % 7 == 0) y = x;
         run8(x, y, 3'b010);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end
endmodule